// File: doc/BRIEF.md
# Paged Framebuffer Scanout Address Generator

This block turns a raster line number and an active-video flag into byte read addresses for an 8-bit-per-pixel framebuffer. The picture is 320 by 240, and it is shown on a 480-line raster. Every pixel lasts two clocks. During that slot the block holds one read address steady, holds the memory output enable high, and pulses a colour-DAC strobe on the second clock.

The output enable also gates the DAC latch. It is high only while pixels are being fetched, so the memory drives the data bus only inside the active part of each line. Memory is split into 256-byte pages. A line does not carry into a higher page when it passes pixel 255. Instead it sets a single bank bit and restarts the low byte at zero. Pixels 256 to 319 therefore land in low bytes 0 to 63 of bank 1, and the other 192 bytes of that bank row are never read. The stored row index is the raster line divided by two, so each stored line appears on two raster lines.

Top module: `scan_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets `pix_en` and `dac_stb` to 0 and `rd_addr` to 0. This holds even when reset is applied in the middle of an active line.
- R2: The first clock edge that samples `active` high after blanking raises `pix_en` for pixel 0. The output enable and the DAC enable are one shared signal.
- R3: Pixel p is presented for exactly two clocks, counted from the edge at which `active` was first sampled high: clocks 2p and 2p+1. `rd_addr` is held steady across both clocks. `dac_stb` is 0 on the first clock of the slot and 1 on the second.
- R4: For pixels 0 to 255, `rd_addr` = {1'b0, row[7:0], p[7:0]}. Bit 16 is the bank bit, bits 15:8 are the row and bits 7:0 are the low byte.
- R5: For pixels 256 to 319, `rd_addr` = {1'b1, row[7:0], p-256}. The address steps directly from low byte 255 in bank 0 to low byte 0 in bank 1, with no extra clock and no intermediate value.
- R6: After the second clock of pixel 319, `pix_en` and `dac_stb` drop to 0 and stay at 0 while `active` remains high.
- R7: One edge after `active` is sampled low, `pix_en` and `dac_stb` are 0. This applies during blanking and when a line is cut short.
- R8: row equals the raster line shifted right by one bit. Raster lines 2k and 2k+1 read the same addresses.
- R9: A line whose active period lasts at least 640 clocks produces exactly 320 `dac_stb` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raster_line | input | 9 | Raster line number (0 to 479) from the timing unit |
| active | input | 1 | Active-video flag from the timing unit |
| rd_addr | output | 17 | Framebuffer byte read address: {bank, row, low byte} |
| pix_en | output | 1 | Shared memory output enable and DAC latch enable |
| dac_stb | output | 1 | DAC strobe, high on the second clock of each pixel slot |

## Verification
The hardest condition to reach is the bank switch at pixel 256, together with the shut-off after pixel 319. Both require the active flag to stay high for hundreds of clocks without a break. A flag that toggles at random would almost never get that far. The stimulus therefore drives whole lines with lengths that vary only a little above 640 clocks, and it adds directed lines that drop the active flag exactly at the page crossing and just before the last pixel.

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int H_PIX    = 320,
  parameter int V_RASTER = 480,
  parameter int COL_W    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [$clog2(V_RASTER)-1:0]           raster_line,
  input  logic                                  active,
  output logic [$clog2(V_RASTER)+COL_W-1:0]     rd_addr,
  output logic                                  pix_en,
  output logic                                  dac_stb
);
  localparam int RL_W    = $clog2(V_RASTER);
  localparam int ROW_W   = RL_W - 1;
  localparam int PAGE    = 1 << COL_W;
  localparam int HI_LAST = H_PIX - 1 - PAGE;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             bank, phase, en, done;

  wire last_pix = bank && (col == HI_LAST[COL_W-1:0]);
  wire page_end = !bank && (col == {COL_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      col   <= '0;
      row   <= '0;
      bank  <= 1'b0;
      phase <= 1'b0;
      en    <= 1'b0;
      done  <= 1'b0;
    end else if (!active) begin
      col   <= '0;
      bank  <= 1'b0;
      phase <= 1'b0;
      en    <= 1'b0;
      done  <= 1'b0;
      row   <= raster_line[RL_W-1:1];
    end else if (!en) begin
      if (!done) begin
        en    <= 1'b1;
        phase <= 1'b0;
        col   <= '0;
        bank  <= 1'b0;
        row   <= raster_line[RL_W-1:1];
      end
    end else if (!phase) begin
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      if (last_pix) begin
        en   <= 1'b0;
        done <= 1'b1;
      end else if (page_end) begin
        col  <= '0;
        bank <= 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign rd_addr = {bank, row, col};
  assign pix_en  = en;
  assign dac_stb = en & phase;
endmodule

module scan_addr_chk #(
  parameter int ADDR_W  = 17,
  parameter int COL_W   = 8,
  parameter int HI_LAST = 63
) (
  input logic              clk,
  input logic              rst,
  input logic              active,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              pix_en,
  input logic              dac_stb
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(active) && !pix_en) |=> (pix_en && !dac_stb && rd_addr[COL_W-1:0] == '0 && !rd_addr[ADDR_W-1]));

  p_slot_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (active && pix_en && !dac_stb) |=> (dac_stb && $stable(rd_addr)));

  p_page_step_r5: assert property (@(posedge clk) disable iff (rst)
    (active && dac_stb && !rd_addr[ADDR_W-1] && rd_addr[COL_W-1:0] == '1)
      |=> (rd_addr[ADDR_W-1] && rd_addr[COL_W-1:0] == '0));

  p_bank_range_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_en && rd_addr[ADDR_W-1]) |-> (rd_addr[COL_W-1:0] <= HI_LAST[COL_W-1:0]));

  p_line_end_r6: assert property (@(posedge clk) disable iff (rst)
    (dac_stb && rd_addr[ADDR_W-1] && rd_addr[COL_W-1:0] == HI_LAST[COL_W-1:0]) |=> !pix_en);

  p_blank_off_r7: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!pix_en && !dac_stb));

  p_row_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (pix_en && $past(pix_en)) |-> $stable(rd_addr[ADDR_W-2:COL_W]));
endmodule

bind scan_addr_gen scan_addr_chk u_chk (
  .clk(clk), .rst(rst), .active(active),
  .rd_addr(rd_addr), .pix_en(pix_en), .dac_stb(dac_stb)
);

// File: tb/sim_scan_addr_gen.sv
module sim_scan_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  raster_line = '0;
  logic        active = 1'b0;
  logic [16:0] rd_addr;
  logic        pix_en, dac_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scan_addr_gen u0 (
    .clk(clk), .rst(rst), .raster_line(raster_line), .active(active),
    .rd_addr(rd_addr), .pix_en(pix_en), .dac_stb(dac_stb)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(int rl, int p);
    int row = rl >> 1;
    if (p < 256) return (row << 8) | p;
    return (1 << 16) | (row << 8) | (p - 256);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_line(int rl, int n, int gap);
    int stb_cnt = 0;
    raster_line = rl[8:0];
    active = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 blank en", int'(pix_en), 0);
      chk("R7 blank stb", int'(dac_stb), 0);
    end
    active = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(posedge clk); @(negedge clk);
      if (t < 640) begin
        int p = t / 2;
        if (t == 0) chk("R2 start en", int'(pix_en), 1);
        else chk("R3 en in slot", int'(pix_en), 1);
        chk("R3 strobe phase", int'(dac_stb), t % 2);
        if (p < 256) chk("R4 R8 addr", int'(rd_addr), exp_addr(rl, p));
        else chk("R5 R8 addr", int'(rd_addr), exp_addr(rl, p));
      end else begin
        chk("R6 en off", int'(pix_en), 0);
        chk("R6 stb off", int'(dac_stb), 0);
      end
      stb_cnt += int'(dac_stb);
    end
    active = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 drop en", int'(pix_en), 0);
    chk("R7 drop stb", int'(dac_stb), 0);
    if (n >= 640) chk("R9 strobe count", stb_cnt, 320);
  endtask

  initial begin
    repeat (198000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset en", int'(pix_en), 0);
    chk("R1 reset stb", int'(dac_stb), 0);
    chk("R1 reset addr", int'(rd_addr), 0);
    rst = 1'b0;

    run_line(0, 640, 2);
    run_line(1, 700, 3);
    run_line(77, 511, 2);
    run_line(77, 513, 2);
    run_line(479, 639, 2);
    run_line(478, 640, 1);

    raster_line = 9'd200;
    active = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 midline en", int'(pix_en), 0);
    chk("R1 midline stb", int'(dac_stb), 0);
    chk("R1 midline addr", int'(rd_addr), 0);
    active = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;

    for (int rl = 0; rl < 480; rl++) begin
      if (rl % 2 == 0 || rl % 32 == 1)
        run_line(rl, 640 + int'($urandom % 6), 1 + int'($urandom % 4));
    end
    summary();
  end
endmodule